// File: doc/BRIEF.md
# Indirect Byte Register Access Bridge

This block lets a host with a 32-bit memory-mapped window reach a 256-entry space of 8-bit registers that belongs to a slow serial bus controller. The host builds one command word that holds an internal address, a data byte and a direction bit, and writes it to the command offset. The bridge then carries out the access over a fixed number of cycles, which stands in for the crossing into the slow internal clock. A busy flag in the same word stays set until the access has finished. For a read, the fetched byte appears in the top byte of that word.

The window has four more registers at fixed offsets. A control register holds a soft reset and a clock-mode field, and the clock mode decides whether internal accesses advance. The other three are an interrupt mask, a write-one-to-clear interrupt clear register and an interrupt status register. A transmit event and a receive event each set one status bit. The interrupt line is high while any status bit with its mask bit set is pending.

Top module: `regwin_bridge`

## Requirements
- R1: After hard reset every window register reads 0 and the interrupt line is low.
- R2: A command accepted at offset 0x04 sets bit 23 (busy) of the command word from the next cycle.
- R3: In clock mode 1 or 2, busy stays high for exactly LATENCY cycles (default 4). A write command (bit 16 = 1) stores byte [15:8] at internal address [7:0] when busy drops.
- R4: A read command (bit 16 = 0) puts the addressed byte into bits [31:24] by the time busy drops. Bits [16:0] echo the last accepted command.
- R5: A command written while busy is set is ignored and sets the sticky error flag, bit 22. Only a soft reset clears that flag.
- R6: In clock modes 0 (off) and 3 (reserved), an access in flight holds still with busy set. Once mode 1 or 2 is selected it resumes with its remaining count.
- R7: Control register bits [2:0] read back as written. While bit 0 (soft reset) is 1: the command word reads 0, any access in flight is dropped, the internal register space is cleared, and commands are ignored without raising the error flag.
- R8: A transmit event sets status bit 1 and a receive event sets status bit 2. Writing a 1 to the matching bit at offset 0x0C clears it. An event in the same cycle as its clear wins, and the clear register reads 0.
- R9: The interrupt line is the OR over status bits 1 and 2 of status AND mask, where a mask bit of 1 enables its interrupt. Only mask bits 1 and 2 can be written; all other bits read 0.
- R10: Clock mode 2 (free-running) completes accesses with the same timing as mode 1 (gated).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_addr | input | 5 | Window byte offset for writes and reads |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the register at host_addr |
| ev_tx | input | 1 | Transmit event pulse |
| ev_rx | input | 1 | Receive event pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an access that is frozen part-way and then resumed, because the clock mode has to change while busy is set. The stimulus issues a command with the clock off, holds it for many cycles, switches to the reserved mode, and then enables the gated mode. It then counts the remaining busy cycles against the latency. A second command is also written on the cycle straight after the first, so that it is rejected while busy. Last, a soft reset is raised in the middle of a write, and the target byte is checked afterwards to show that it was never written.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int HOST_AW  = 5;
    localparam int HOST_DW  = 32;
    localparam int IREG_AW  = 8;
    localparam int IREG_DW  = 8;

    // command word field positions (the host software decodes these)
    localparam int CMD_WDAT_LSB = IREG_AW;
    localparam int CMD_WE_BIT   = 16;
    localparam int CMD_ERR_BIT  = 22;
    localparam int CMD_BUSY_BIT = 23;
    localparam int CMD_RDAT_LSB = 24;
    localparam int CMD_PAD_W    = CMD_ERR_BIT - CMD_WE_BIT - 1;

    // interrupt bit positions inside the mask / clear / status words
    localparam int IRQ_TX_BIT = 1;
    localparam int IRQ_RX_BIT = 2;
    localparam int IRQ_N      = 2;

    localparam int CTRL_W = 3;

    typedef enum logic [HOST_AW-1:0] {
        OFF_CTRL  = 5'h00,
        OFF_CMD   = 5'h04,
        OFF_IMASK = 5'h08,
        OFF_ICLR  = 5'h0C,
        OFF_ISTAT = 5'h10
    } win_off_e;

    typedef enum logic [1:0] {
        CLKM_OFF   = 2'd0,
        CLKM_GATED = 2'd1,
        CLKM_FREE  = 2'd2,
        CLKM_RSVD  = 2'd3
    } clk_mode_e;

endpackage

// File: rtl/regwin_bytefile.sv
module regwin_bytefile #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem_d[i] = '0;
        end else if (we) begin
            mem_d[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/regwin_engine.sv
module regwin_engine
    import regwin_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               srst,
    input  logic               run,
    input  logic               start,
    input  logic [HOST_DW-1:0] cmd_in,
    input  logic [IREG_DW-1:0] file_rdata,
    output logic               file_we,
    output logic [IREG_AW-1:0] file_addr,
    output logic [IREG_DW-1:0] file_wdata,
    output logic [HOST_DW-1:0] cmd_word,
    output logic               busy,
    output logic               err
);
    localparam int CW = $clog2(LAT + 1);

    typedef struct packed {
        logic [IREG_AW-1:0] addr;
        logic [IREG_DW-1:0] wdat;
        logic               we;
        logic               busy;
        logic               err;
        logic [CW-1:0]      cnt;
        logic [IREG_DW-1:0] rdat;
    } eng_t;

    eng_t q, d;
    logic done;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (srst) begin
            d = '0;
        end else begin
            if (q.busy && run) begin
                d.cnt = q.cnt - 1'b1;
                if (q.cnt == CW'(1)) begin
                    d.busy = 1'b0;
                    done   = 1'b1;
                    if (!q.we) d.rdat = file_rdata;
                end
            end
            if (start) begin
                if (q.busy) begin
                    d.err = 1'b1;
                end else begin
                    d.addr = cmd_in[IREG_AW-1:0];
                    d.wdat = cmd_in[CMD_WDAT_LSB +: IREG_DW];
                    d.we   = cmd_in[CMD_WE_BIT];
                    d.busy = 1'b1;
                    d.cnt  = CW'(LAT);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign file_we    = done && q.we;
    assign file_addr  = q.addr;
    assign file_wdata = q.wdat;
    assign busy       = q.busy;
    assign err        = q.err;
    assign cmd_word   = {q.rdat, q.busy, q.err, {CMD_PAD_W{1'b0}}, q.we, q.wdat, q.addr};

endmodule

// File: rtl/regwin_irq.sv
module regwin_irq
    import regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic              clr_wr,
    input  logic [IRQ_N-1:0]  wbits,
    input  logic [IRQ_N-1:0]  events,
    output logic [IRQ_N-1:0]  mask,
    output logic [IRQ_N-1:0]  stat,
    output logic              irq
);
    typedef struct packed {
        logic [IRQ_N-1:0] mask;
        logic [IRQ_N-1:0] stat;
    } irq_t;

    irq_t q, d;

    always_comb begin
        d = q;
        if (mask_wr) d.mask = wbits;
        if (clr_wr)  d.stat = d.stat & ~wbits;
        d.stat = d.stat | events;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mask = q.mask;
    assign stat = q.stat;
    assign irq  = |(q.stat & q.mask);

endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    input  logic               ev_tx,
    input  logic               ev_rx,
    output logic               irq_o
);
    logic [CTRL_W-1:0]  ctrl_q, ctrl_d;
    logic               srst, run;
    logic               cmd_wr, mask_wr, clr_wr;
    logic [HOST_DW-1:0] cmd_word;
    logic               eng_busy, eng_err;
    logic               f_we;
    logic [IREG_AW-1:0] f_addr;
    logic [IREG_DW-1:0] f_wdata, f_rdata;
    logic [IRQ_N-1:0]   irq_mask, irq_stat;
    clk_mode_e          mode;

    assign cmd_wr  = host_wr && (host_addr == OFF_CMD);
    assign mask_wr = host_wr && (host_addr == OFF_IMASK);
    assign clr_wr  = host_wr && (host_addr == OFF_ICLR);

    always_comb begin
        ctrl_d = ctrl_q;
        if (host_wr && (host_addr == OFF_CTRL)) ctrl_d = host_wdata[CTRL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign srst = ctrl_q[0];
    assign mode = clk_mode_e'(ctrl_q[2:1]);
    assign run  = (mode == CLKM_GATED) || (mode == CLKM_FREE);

    regwin_engine #(.LAT(LATENCY)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst       (srst),
        .run        (run),
        .start      (cmd_wr),
        .cmd_in     (host_wdata),
        .file_rdata (f_rdata),
        .file_we    (f_we),
        .file_addr  (f_addr),
        .file_wdata (f_wdata),
        .cmd_word   (cmd_word),
        .busy       (eng_busy),
        .err        (eng_err)
    );

    regwin_bytefile #(.AW(IREG_AW), .DW(IREG_DW)) u_file (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (srst),
        .we    (f_we),
        .addr  (f_addr),
        .wdata (f_wdata),
        .rdata (f_rdata)
    );

    regwin_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_wr (mask_wr),
        .clr_wr  (clr_wr),
        .wbits   (host_wdata[IRQ_RX_BIT:IRQ_TX_BIT]),
        .events  ({ev_rx, ev_tx}),
        .mask    (irq_mask),
        .stat    (irq_stat),
        .irq     (irq_o)
    );

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFF_CTRL:  host_rdata[CTRL_W-1:0] = ctrl_q;
            OFF_CMD:   host_rdata = cmd_word;
            OFF_IMASK: host_rdata[IRQ_RX_BIT:IRQ_TX_BIT] = irq_mask;
            OFF_ISTAT: host_rdata[IRQ_RX_BIT:IRQ_TX_BIT] = irq_stat;
            default:   host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/regwin_checks.sv
module regwin_checks #(
    parameter int LAT = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr,
    input logic       srst,
    input logic       run,
    input logic       busy,
    input logic       err,
    input logic       ev_tx,
    input logic       ev_rx,
    input logic [1:0] stat,
    input logic [1:0] mask,
    input logic       irq
);
    logic [31:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             win_q <= '0;
        else if (!busy || srst) win_q <= '0;
        else if (run)           win_q <= win_q + 1;
    end

    a_r2_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && !srst) |=> busy);

    a_r3_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run && !srst) |-> (win_q < LAT));

    a_r5_reject_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy && !srst) |=> err);

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !srst) |=> err);

    a_r6_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !run && !srst) |=> busy);

    a_r7_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!busy && !err));

    a_r8_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx |=> stat[0]);

    a_r8_rx_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx |=> stat[1]);

    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 2'b00) |-> !irq);

endmodule

bind regwin_bridge regwin_checks #(.LAT(LATENCY)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_wr (cmd_wr),
    .srst   (srst),
    .run    (run),
    .busy   (eng_busy),
    .err    (eng_err),
    .ev_tx  (ev_tx),
    .ev_rx  (ev_rx),
    .stat   (irq_stat),
    .mask   (irq_mask),
    .irq    (irq_o)
);

// File: tb/regwin_bridge_test.sv
`timescale 1ns/1ps
module regwin_bridge_test;
    import regwin_pkg::*;

    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr;
    logic [4:0]  host_addr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic        ev_tx, ev_rx;
    logic        irq_o;

    always #2 clk = ~clk;

    regwin_bridge #(.LATENCY(LAT)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .ev_tx      (ev_tx),
        .ev_rx      (ev_rx),
        .irq_o      (irq_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        string       tag;
        logic [4:0]  addr;
        logic [31:0] exp;
    } exp_t;

    exp_t sbq[$];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // driver side: queue an expected window read
    task automatic push_rd(string tag, logic [4:0] a, logic [31:0] e);
        exp_t it;
        it.tag = tag; it.addr = a; it.exp = e;
        sbq.push_back(it);
    endtask

    // monitor side: pop and compare against the live window
    task automatic drain();
        while (sbq.size() > 0) begin
            exp_t it;
            it = sbq.pop_front();
            host_addr = it.addr;
            #0.5;
            chk(it.tag, host_rdata, it.exp);
        end
    endtask

    task automatic host_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    function automatic logic [31:0] cmd(logic we, logic [7:0] a, logic [7:0] d);
        return {15'h0, we, d, a};
    endfunction

    task automatic wait_idle(output int n);
        n = 0;
        host_addr = OFF_CMD;
        #0.5;
        while (host_rdata[CMD_BUSY_BIT] && n < 1000) begin
            n++;
            @(negedge clk);
            #0.5;
        end
    endtask

    task automatic read_byte(logic [7:0] a, output logic [7:0] b);
        int n;
        host_write(OFF_CMD, cmd(1'b0, a, 8'h00));
        wait_idle(n);
        b = host_rdata[31:24];
    endtask

    task automatic pulse_ev(bit tx, bit rx);
        @(negedge clk);
        ev_tx = tx; ev_rx = rx;
        @(negedge clk);
        ev_tx = 1'b0; ev_rx = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int          n;
        logic [7:0]  b;
        logic [7:0]  addrs [4];
        logic [7:0]  vals  [4];
        addrs = '{8'h00, 8'hFF, 8'h7E, 8'h3C};
        vals  = '{8'h01, 8'h80, 8'h5A, 8'hA5};

        rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
        ev_tx = 1'b0; ev_rx = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        push_rd("R1 ctrl", OFF_CTRL, 32'h0);
        push_rd("R1 cmd", OFF_CMD, 32'h0);
        push_rd("R1 mask", OFF_IMASK, 32'h0);
        push_rd("R1 stat", OFF_ISTAT, 32'h0);
        drain();
        chk("R1 irq", {31'h0, irq_o}, 32'h0);

        // R7 control readback, gated mode
        host_write(OFF_CTRL, 32'h2);
        push_rd("R7 ctrl readback", OFF_CTRL, 32'h2);
        drain();

        // R2 / R3 write access timing
        host_write(OFF_CMD, cmd(1'b1, 8'h3C, 8'hA5));
        host_addr = OFF_CMD; #0.5;
        chk("R2 busy next cycle", {31'h0, host_rdata[CMD_BUSY_BIT]}, 32'h1);
        wait_idle(n);
        chk("R3 busy cycles", n, LAT);

        // R4 read returns byte in top field and echoes command
        host_write(OFF_CMD, cmd(1'b0, 8'h3C, 8'h00));
        wait_idle(n);
        chk("R4 read word", host_rdata, {8'hA5, 24'h00_003C});

        // R3 / R4 several patterns
        for (int i = 0; i < 3; i++) begin
            host_write(OFF_CMD, cmd(1'b1, addrs[i], vals[i]));
            wait_idle(n);
        end
        for (int i = 0; i < 4; i++) begin
            read_byte(addrs[i], b);
            chk($sformatf("R3 R4 byte at 0x%02h", addrs[i]), {24'h0, b}, {24'h0, vals[i]});
        end

        // R10 free-running mode
        host_write(OFF_CTRL, 32'h4);
        host_write(OFF_CMD, cmd(1'b1, 8'h11, 8'hC3));
        wait_idle(n);
        chk("R10 busy cycles", n, LAT);
        read_byte(8'h11, b);
        chk("R10 byte", {24'h0, b}, 32'hC3);

        // R5 command while busy
        host_write(OFF_CTRL, 32'h2);
        host_write(OFF_CMD, cmd(1'b1, 8'h20, 8'h11));
        host_write(OFF_CMD, cmd(1'b1, 8'h21, 8'h99));
        wait_idle(n);
        chk("R5 error flag", {31'h0, host_rdata[CMD_ERR_BIT]}, 32'h1);
        chk("R5 echo keeps first", {16'h0, host_rdata[15:0]}, 32'h1120);
        read_byte(8'h21, b);
        chk("R5 second ignored", {24'h0, b}, 32'h0);
        read_byte(8'h20, b);
        chk("R5 first stored", {24'h0, b}, 32'h11);
        chk("R5 error sticky", {31'h0, host_rdata[CMD_ERR_BIT]}, 32'h1);

        // R6 frozen access and resume
        host_write(OFF_CTRL, 32'h0);
        host_write(OFF_CMD, cmd(1'b1, 8'h40, 8'h77));
        repeat (10) @(negedge clk);
        host_addr = OFF_CMD; #0.5;
        chk("R6 held in mode 0", {31'h0, host_rdata[CMD_BUSY_BIT]}, 32'h1);
        host_write(OFF_CTRL, 32'h6);
        repeat (5) @(negedge clk);
        host_addr = OFF_CMD; #0.5;
        chk("R6 held in mode 3", {31'h0, host_rdata[CMD_BUSY_BIT]}, 32'h1);
        host_write(OFF_CTRL, 32'h2);
        wait_idle(n);
        chk("R6 resume cycles", n, LAT);
        read_byte(8'h40, b);
        chk("R6 byte", {24'h0, b}, 32'h77);

        // R7 soft reset mid-access
        host_write(OFF_CMD, cmd(1'b1, 8'h50, 8'h33));
        host_write(OFF_CTRL, 32'h3);
        @(negedge clk);
        push_rd("R7 cmd word cleared", OFF_CMD, 32'h0);
        push_rd("R7 ctrl readback", OFF_CTRL, 32'h3);
        drain();
        host_write(OFF_CMD, cmd(1'b1, 8'h51, 8'h01));
        @(negedge clk);
        push_rd("R7 command ignored", OFF_CMD, 32'h0);
        drain();
        host_write(OFF_CTRL, 32'h2);
        read_byte(8'h3C, b);
        chk("R7 space cleared", {24'h0, b}, 32'h0);
        chk("R7 no error after", {31'h0, host_rdata[CMD_ERR_BIT]}, 32'h0);
        read_byte(8'h50, b);
        chk("R7 aborted write", {24'h0, b}, 32'h0);
        read_byte(8'h51, b);
        chk("R7 ignored write", {24'h0, b}, 32'h0);

        // R8 / R9 interrupts
        pulse_ev(1'b1, 1'b0);
        push_rd("R8 tx status", OFF_ISTAT, 32'h2);
        drain();
        chk("R9 masked irq", {31'h0, irq_o}, 32'h0);
        host_write(OFF_IMASK, 32'hFFFF_FFFF);
        push_rd("R9 mask bits", OFF_IMASK, 32'h6);
        drain();
        chk("R9 irq enabled", {31'h0, irq_o}, 32'h1);
        host_write(OFF_ICLR, 32'h2);
        push_rd("R8 cleared", OFF_ISTAT, 32'h0);
        push_rd("R8 clear reads 0", OFF_ICLR, 32'h0);
        drain();
        chk("R9 irq dropped", {31'h0, irq_o}, 32'h0);
        pulse_ev(1'b0, 1'b1);
        push_rd("R8 rx status", OFF_ISTAT, 32'h4);
        drain();
        chk("R9 rx irq", {31'h0, irq_o}, 32'h1);
        host_write(OFF_IMASK, 32'h2);
        chk("R9 rx masked", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        ev_rx = 1'b1; host_wr = 1'b1; host_addr = OFF_ICLR; host_wdata = 32'h4;
        @(negedge clk);
        ev_rx = 1'b0; host_wr = 1'b0;
        push_rd("R8 set wins", OFF_ISTAT, 32'h4);
        drain();
        host_write(OFF_ICLR, 32'h4);
        push_rd("R8 rx cleared", OFF_ISTAT, 32'h0);
        drain();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule